// File: doc/BRIEF.md
# Eight-Bit ALU with Condition-Code Update

This block performs the byte-wide arithmetic, logical, shift and decimal-adjust work of a small accumulator processor. Each clock it takes an operation code, an accumulator operand, a second operand and the present condition-code byte. It returns the byte result, the new condition-code byte and a flag that says whether the result should be written back to a register. Operand fetch, addressing, word-wide arithmetic and multiply belong to the surrounding datapath.

The carry flag of the incoming condition-code byte acts as the carry or borrow input. The rotate operations also use it as the inserted bit, and the decimal adjust reads it together with the half-carry flag. Each operation changes only the flags listed for it and copies every other flag unchanged. Bits 4, 6 and 7 of the condition-code byte are never touched. The combinational core feeds one output register, so all results appear one clock after the operands.

Top module: `alu8_cc`

## Requirements
- R1: `op_in` selects the operation: ADD=0, ADC=1, SUB=2, SBC=3, CMP=4, AND=5, OR=6, EOR=7, BIT=8, LD=9, NEG=10, COM=11, LSR=12, ASR=13, ROR=14, ASL=15, ROL=16, INC=17, DEC=18, TST=19, CLR=20, DAA=21. Unary operations act on `a_in`, and LD passes `b_in` through. `wb_out` is 0 for CMP, BIT and TST and 1 for every other defined code.
- R2: ADD, ADC and ASL form a 9-bit sum r of x+y(+carry). ADD uses x=a, y=b. ADC also adds the incoming carry. ASL uses x=y=a with no carry. C is r[8], H is bit 4 of x^y^r, V is bit 7 of x^y^r^(r>>1), and N and Z come from r[7:0].
- R3: SUB, SBC, CMP and NEG form a 9-bit difference r of x-y(-borrow). SUB and CMP use x=a, y=b. SBC also subtracts the incoming carry. NEG uses x=0, y=a. Flags follow the same formulas as R2.
- R4: AND, OR, EOR, BIT, LD and TST set N and Z from the 8-bit result and clear V. They leave C and H unchanged.
- R5: COM returns ~a, sets C, clears V and sets N and Z from the result. H is unchanged.
- R6: CLR returns 0x00 with N=0, Z=1, V=0 and C=0. H is unchanged.
- R7: INC returns a+1 and DEC returns a-1, both modulo 256. V is set exactly when an INC result is 0x80 or a DEC result is 0x7F. N and Z follow the result. C and H are unchanged.
- R8: LSR, ASR and ROR shift right and move a[0] into C. LSR inserts 0 at bit 7, ASR repeats a[7], and ROR inserts the incoming C. N and Z follow the result. V and H are unchanged.
- R9: ROL shifts left, moves a[7] into C and inserts the incoming C at bit 0. N and Z follow the result. V and H are unchanged.
- R10: DAA first adds 0x06 when H is set or the low nibble of a exceeds 9. It then adds 0x60 when C is set or bits 7:4 of that partial sum exceed 9. The result is bits 7:0 of the sum and C is bit 8. No other flag changes.
- R11: Flag positions are C=bit 0, V=bit 1, Z=bit 2, N=bit 3, H=bit 5. Bits 4, 6 and 7 of `cc_out` always equal those of `cc_in`.
- R12: All outputs are registered. They reflect the inputs from the preceding rising edge. A synchronous active-low reset clears `res_out`, `cc_out` and `wb_out` to zero.
- R13: Codes 22 to 31 are undefined. They give result 0x00, `cc_out` equal to `cc_in` and `wb_out`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_in | input | 5 | Operation code |
| a_in | input | 8 | Accumulator operand |
| b_in | input | 8 | Second operand |
| cc_in | input | 8 | Present condition-code byte |
| res_out | output | 8 | Registered result |
| cc_out | output | 8 | Registered updated condition-code byte |
| wb_out | output | 1 | Registered writeback request |

## Verification
Every result, flag byte and writeback bit is due exactly one rising edge after its operands are presented. Reset takes effect on the same rising edge at which it is sampled low. The bench drives a new vector at each falling edge. At the next falling edge it compares all three outputs against a behavioural model evaluated on the vector that was captured in between, so no check ever samples at the edge where the outputs change. The embedded properties use the same one-edge relation through `|=>` and single-step `$past`.

// File: rtl/alu8_pkg.sv
// Package: shared operation codes and condition-code bit positions for
// the eight-bit ALU. Assumes a byte-wide datapath with a nibble half-carry.
package alu8_pkg;

    localparam int unsigned ALU_W   = 8;
    localparam int unsigned OP_W    = 5;
    localparam int unsigned NIB_BIT = 4;

    localparam int unsigned CC_C = 0;
    localparam int unsigned CC_V = 1;
    localparam int unsigned CC_Z = 2;
    localparam int unsigned CC_N = 3;
    localparam int unsigned CC_H = 5;

    typedef enum logic [OP_W-1:0] {
        OP_ADD = 5'd0,  OP_ADC = 5'd1,  OP_SUB = 5'd2,  OP_SBC = 5'd3,
        OP_CMP = 5'd4,  OP_AND = 5'd5,  OP_OR  = 5'd6,  OP_EOR = 5'd7,
        OP_BIT = 5'd8,  OP_LD  = 5'd9,  OP_NEG = 5'd10, OP_COM = 5'd11,
        OP_LSR = 5'd12, OP_ASR = 5'd13, OP_ROR = 5'd14, OP_ASL = 5'd15,
        OP_ROL = 5'd16, OP_INC = 5'd17, OP_DEC = 5'd18, OP_TST = 5'd19,
        OP_CLR = 5'd20, OP_DAA = 5'd21
    } alu_op_e;

    localparam int unsigned OP_LAST = 21;

    typedef enum logic [1:0] {
        SH_LSR = 2'd0,
        SH_ASR = 2'd1,
        SH_ROR = 2'd2,
        SH_ROL = 2'd3
    } shift_e;

endpackage

// File: rtl/alu8_addsub.sv
// Adder/subtractor with carry, half-carry and signed overflow.
// It forms a (W+1)-bit sum or difference. The top bit is the carry or borrow.
// Overflow is taken from the top bits of x^y^r^(r>>1).
// Assumes W > NIB so that the half-carry bit exists.
module alu8_addsub #(
    parameter int unsigned W   = alu8_pkg::ALU_W,
    parameter int unsigned NIB = alu8_pkg::NIB_BIT
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic         cin,
    input  logic         sub,
    output logic [W-1:0] r,
    output logic         c_out,
    output logic         h_out,
    output logic         v_out
);
    logic [W:0]   wide;
    logic [W:0]   cin_ext;
    logic [W-1:0] hmix;
    logic [W-1:0] vmix;

    // Form the extended sum or difference.
    always_comb begin
        cin_ext = {{W{1'b0}}, cin};
        if (sub) wide = {1'b0, x} - {1'b0, y} - cin_ext;
        else     wide = {1'b0, x} + {1'b0, y} + cin_ext;
    end

    // Derive the carry, half-carry and overflow from the sum bits.
    always_comb begin
        r     = wide[W-1:0];
        c_out = wide[W];
        hmix  = x ^ y ^ wide[W-1:0];
        vmix  = x ^ y ^ wide[W-1:0] ^ wide[W:1];
        h_out = hmix[NIB];
        v_out = vmix[W-1];
    end
endmodule

// File: rtl/alu8_shift.sv
// Single-bit shifter and rotator. Right shifts move bit 0 into carry.
// Left rotate moves the top bit into carry. The rotates insert the
// incoming carry at the vacated position.
module alu8_shift #(
    parameter int unsigned W = alu8_pkg::ALU_W
) (
    input  logic [W-1:0]    a,
    input  logic            cin,
    input  alu8_pkg::shift_e mode,
    output logic [W-1:0]    r,
    output logic            c_out
);
    import alu8_pkg::*;

    // Select the fill bit and direction for the requested shift.
    always_comb begin
        unique case (mode)
            SH_LSR: begin r = {1'b0,    a[W-1:1]}; c_out = a[0];   end
            SH_ASR: begin r = {a[W-1],  a[W-1:1]}; c_out = a[0];   end
            SH_ROR: begin r = {cin,     a[W-1:1]}; c_out = a[0];   end
            default: begin r = {a[W-2:0], cin};    c_out = a[W-1]; end
        endcase
    end
endmodule

// File: rtl/alu8_daa.sv
// Decimal adjust after a binary add of two packed BCD bytes.
// It adds 6 to the low digit and then 0x60 to the high digit, each when its
// flag is set or its digit exceeds 9. The carry out is bit 8 of the sum.
// Assumes a byte-wide operand.
module alu8_daa #(
    parameter int unsigned W = alu8_pkg::ALU_W
) (
    input  logic [W-1:0] a,
    input  logic         h_in,
    input  logic         c_in,
    output logic [W-1:0] r,
    output logic         c_out
);
    localparam logic [W:0] LO_FIX = (W+1)'(6);
    localparam logic [W:0] HI_FIX = (W+1)'(8'h60);
    localparam logic [3:0] DIGIT_MAX = 4'd9;

    logic [W:0] step1;
    logic [W:0] step2;

    // Correct the low digit, then the high digit of the partial sum.
    always_comb begin
        step1 = {1'b0, a};
        if (h_in || (step1[3:0] > DIGIT_MAX)) step1 = step1 + LO_FIX;
        step2 = step1;
        if (c_in || (step1[7:4] > DIGIT_MAX)) step2 = step1 + HI_FIX;
        r     = step2[W-1:0];
        c_out = step2[W];
    end
endmodule

// File: rtl/alu8_cc.sv
// Top of the eight-bit ALU. It decodes the operation, steers the operands to
// the adder, shifter and decimal-adjust units, merges each operation's flag
// rule into the incoming condition-code byte and registers the result.
// Assumes the carry flag of cc_in is the carry/borrow/rotate input.
// Undefined codes produce no writeback and leave the flags alone.
module alu8_cc #(
    parameter int unsigned W  = alu8_pkg::ALU_W,
    parameter int unsigned OW = alu8_pkg::OP_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [OW-1:0] op_in,
    input  logic [W-1:0]  a_in,
    input  logic [W-1:0]  b_in,
    input  logic [W-1:0]  cc_in,
    output logic [W-1:0]  res_out,
    output logic [W-1:0]  cc_out,
    output logic          wb_out
);
    import alu8_pkg::*;

    localparam logic [W-1:0] ONE     = W'(1);
    localparam logic [W-1:0] INC_OVF = {1'b1, {(W-1){1'b0}}};
    localparam logic [W-1:0] DEC_OVF = {1'b0, {(W-1){1'b1}}};

    alu_op_e      op;
    logic         c_flag;

    logic [W-1:0] as_x, as_y, as_r;
    logic         as_cin, as_sub, as_c, as_h, as_v;
    shift_e       sh_mode;
    logic [W-1:0] sh_r;
    logic         sh_c;
    logic [W-1:0] da_r;
    logic         da_c;

    logic [W-1:0] res_d, cc_d;
    logic         wb_d;

    assign op     = alu_op_e'(op_in);
    assign c_flag = cc_in[CC_C];

    // Steer operands and carry into the shared adder/subtractor.
    always_comb begin
        as_x = a_in; as_y = b_in; as_cin = 1'b0; as_sub = 1'b0;
        case (op)
            OP_ADC: as_cin = c_flag;
            OP_SUB, OP_CMP: as_sub = 1'b1;
            OP_SBC: begin as_sub = 1'b1; as_cin = c_flag; end
            OP_NEG: begin as_sub = 1'b1; as_x = '0; as_y = a_in; end
            OP_ASL: as_y = a_in;
            default: ;
        endcase
    end

    // Map the operation code onto the shifter mode.
    always_comb begin
        case (op)
            OP_ASR:  sh_mode = SH_ASR;
            OP_ROR:  sh_mode = SH_ROR;
            OP_ROL:  sh_mode = SH_ROL;
            default: sh_mode = SH_LSR;
        endcase
    end

    alu8_addsub #(.W(W)) u_addsub (
        .x(as_x), .y(as_y), .cin(as_cin), .sub(as_sub),
        .r(as_r), .c_out(as_c), .h_out(as_h), .v_out(as_v)
    );

    alu8_shift #(.W(W)) u_shift (
        .a(a_in), .cin(c_flag), .mode(sh_mode), .r(sh_r), .c_out(sh_c)
    );

    alu8_daa #(.W(W)) u_daa (
        .a(a_in), .h_in(cc_in[CC_H]), .c_in(c_flag), .r(da_r), .c_out(da_c)
    );

    // Select the result and apply the operation's flag rule.
    always_comb begin
        res_d = '0;
        cc_d  = cc_in;
        wb_d  = 1'b1;
        case (op)
            OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_CMP, OP_NEG, OP_ASL: begin
                res_d      = as_r;
                cc_d[CC_H] = as_h;
                cc_d[CC_V] = as_v;
                cc_d[CC_C] = as_c;
                wb_d       = (op != OP_CMP);
            end
            OP_AND: res_d = a_in & b_in;
            OP_BIT: begin res_d = a_in & b_in; wb_d = 1'b0; end
            OP_OR:  res_d = a_in | b_in;
            OP_EOR: res_d = a_in ^ b_in;
            OP_LD:  res_d = b_in;
            OP_TST: begin res_d = a_in; wb_d = 1'b0; end
            OP_COM: begin res_d = ~a_in; cc_d[CC_C] = 1'b1; end
            OP_CLR: begin res_d = '0; cc_d[CC_C] = 1'b0; end
            OP_INC: begin res_d = a_in + ONE; cc_d[CC_V] = (res_d == INC_OVF); end
            OP_DEC: begin res_d = a_in - ONE; cc_d[CC_V] = (res_d == DEC_OVF); end
            OP_LSR, OP_ASR, OP_ROR, OP_ROL: begin
                res_d      = sh_r;
                cc_d[CC_C] = sh_c;
            end
            OP_DAA: begin res_d = da_r; cc_d[CC_C] = da_c; end
            default: wb_d = 1'b0;
        endcase
        // Every defined code except DAA refreshes N and Z.
        if (op_in <= OW'(OP_LAST) && op != OP_DAA) begin
            cc_d[CC_N] = res_d[W-1];
            cc_d[CC_Z] = (res_d == '0);
        end
        // Logical group, complement and clear drop the overflow flag.
        case (op)
            OP_AND, OP_OR, OP_EOR, OP_BIT, OP_LD, OP_TST, OP_COM, OP_CLR:
                cc_d[CC_V] = 1'b0;
            default: ;
        endcase
    end

    // Register the outputs with a synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_out <= '0;
            cc_out  <= '0;
            wb_out  <= 1'b0;
        end else begin
            res_out <= res_d;
            cc_out  <= cc_d;
            wb_out  <= wb_d;
        end
    end

    // Compare, bit test and test never request a writeback.
    assert_no_wb_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (op_in == OW'(OP_CMP) || op_in == OW'(OP_BIT) || op_in == OW'(OP_TST))
        |=> !wb_out);

    // Complement yields the inverse with carry set and overflow clear.
    assert_com_inverse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_in == OW'(OP_COM)) |=>
        (res_out == ~$past(a_in) && cc_out[CC_C] && !cc_out[CC_V]));

    // Clear yields zero with the fixed flag pattern.
    assert_clr_result_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_in == OW'(OP_CLR)) |=>
        (res_out == '0 && cc_out[3:0] == 4'b0100 && wb_out));

    // Increment overflow exactly at the signed boundary; carry kept.
    assert_inc_ovf_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_in == OW'(OP_INC)) |=>
        (cc_out[CC_V] == (res_out == INC_OVF) && cc_out[CC_C] == $past(cc_in[CC_C])));

    // Decrement overflow exactly at the signed boundary; carry kept.
    assert_dec_ovf_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_in == OW'(OP_DEC)) |=>
        (cc_out[CC_V] == (res_out == DEC_OVF) && cc_out[CC_C] == $past(cc_in[CC_C])));

    // Unassigned condition-code bits always pass straight through.
    assert_cc_passthru_R11: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (cc_out[7:6] == $past(cc_in[7:6]) && cc_out[4] == $past(cc_in[4])));

    // Undefined codes leave flags untouched and request nothing.
    assert_undef_op_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (op_in > OW'(OP_LAST)) |=>
        (!wb_out && res_out == '0 && cc_out == $past(cc_in)));
endmodule

// File: tb/test_alu8_cc.sv
`timescale 1ns/1ps
// Bench: drives one vector per clock, predicts each registered output
// with a behavioural model and compares at the following falling edge.
module test_alu8_cc;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] op_in = '0;
    logic [7:0] a_in = '0, b_in = '0, cc_in = '0;
    logic [7:0] res_out, cc_out;
    logic       wb_out;

    int  n_vec = 0;
    int  n_bad = 0;
    bit  pending = 0;
    bit  done = 0;
    logic [16:0] exp_q;
    string       tag_q;

    always #2 clk = ~clk;

    alu8_cc i_alu8_cc (
        .clk(clk), .rst_n(rst_n), .op_in(op_in), .a_in(a_in), .b_in(b_in),
        .cc_in(cc_in), .res_out(res_out), .cc_out(cc_out), .wb_out(wb_out)
    );

    // Requirement tag that governs each operation code.
    function automatic string req_of(int op);
        case (op)
            0, 1, 15: return "R2";
            2, 3, 4, 10: return "R3";
            5, 6, 7, 8, 9, 19: return "R4";
            11: return "R5";
            20: return "R6";
            17, 18: return "R7";
            12, 13, 14: return "R8";
            16: return "R9";
            21: return "R10";
            default: return "R13";
        endcase
    endfunction

    // Behavioural model: returns {wb, cc, result}.
    function automatic logic [16:0] model(int op, int a, int b, int cc);
        int r = 0, c = cc & 1, ncc = cc, s, x, y;
        bit wb = 1, nz = 1, arith = 0, sub = 0;
        case (op)
            0: begin x = a; y = b; s = x + y; arith = 1; end
            1: begin x = a; y = b; s = x + y + c; arith = 1; end
            15: begin x = a; y = a; s = x + y; arith = 1; end
            2, 4: begin x = a; y = b; s = (x - y) & 'h1FF; arith = 1; end
            3: begin x = a; y = b; s = (x - y - c) & 'h1FF; arith = 1; end
            10: begin x = 0; y = a; s = (0 - a) & 'h1FF; arith = 1; end
            5, 8: r = a & b;
            6: r = a | b;
            7: r = a ^ b;
            9: r = b;
            19: r = a;
            11: begin r = 255 - a; ncc = ncc | 1; end
            20: begin r = 0; ncc = ncc & ~1; end
            17: begin r = (a + 1) % 256; ncc = (ncc & ~2) | ((r == 128) ? 2 : 0); end
            18: begin r = (a + 255) % 256; ncc = (ncc & ~2) | ((r == 127) ? 2 : 0); end
            12: begin r = a / 2; ncc = (ncc & ~1) | (a & 1); end
            13: begin r = a / 2 + (a & 128); ncc = (ncc & ~1) | (a & 1); end
            14: begin r = a / 2 + c * 128; ncc = (ncc & ~1) | (a & 1); end
            16: begin r = (a * 2) % 256 + c; ncc = (ncc & ~1) | (a / 128); end
            21: begin
                s = a;
                if ((cc & 'h20) != 0 || (s % 16) > 9) s = s + 6;
                if (c == 1 || ((s / 16) % 16) > 9) s = s + 'h60;
                r = s % 256;
                ncc = (ncc & ~1) | ((s / 256) % 2);
                nz = 0;
            end
            default: begin r = 0; wb = 0; nz = 0; end
        endcase
        if (arith) begin
            r = s % 256;
            ncc = ncc & ~('h20 | 2 | 1);
            if ((((x ^ y ^ s) / 16) % 2) == 1) ncc = ncc | 'h20;
            if ((((x ^ y ^ s ^ (s / 2)) / 128) % 2) == 1) ncc = ncc | 2;
            if (s >= 256) ncc = ncc | 1;
        end
        if (op inside {5, 6, 7, 8, 9, 19, 11, 20}) ncc = ncc & ~2;
        if (op inside {4, 8, 19}) wb = 0;
        if (nz) begin
            ncc = ncc & ~('h0C);
            if (r >= 128) ncc = ncc | 8;
            if (r == 0) ncc = ncc | 4;
        end
        return {wb, ncc[7:0], r[7:0]};
    endfunction

    // Compare the registered outputs against the pending expectation.
    task automatic check_pending();
        if (pending) begin
            n_vec++;
            if ({wb_out, cc_out, res_out} !== exp_q) begin
                n_bad++;
                $display("FAIL %s: got wb=%b cc=%02h res=%02h, expected wb=%b cc=%02h res=%02h",
                         tag_q, wb_out, cc_out, res_out, exp_q[16], exp_q[15:8], exp_q[7:0]);
            end
        end
        pending = 0;
    endtask

    // Apply one vector at a falling edge and record what is due next.
    task automatic apply(int op, int a, int b, int cc);
        @(negedge clk);
        check_pending();
        op_in = op[4:0]; a_in = a[7:0]; b_in = b[7:0]; cc_in = cc[7:0];
        exp_q = model(op, a, b, cc);
        tag_q = req_of(op);
        pending = 1;
    endtask

    // Reset check: all outputs zero after a sampled low reset (R12).
    task automatic reset_check();
        @(negedge clk);
        check_pending();
        rst_n = 0;
        op_in = 5'd11; a_in = 8'h00;
        @(negedge clk);
        n_vec++;
        if ({wb_out, cc_out, res_out} !== 17'h0) begin
            n_bad++;
            $display("FAIL R12: reset outputs got %b/%02h/%02h, expected 0/00/00",
                     wb_out, cc_out, res_out);
        end
        rst_n = 1;
    endtask

    initial begin
        reset_check();
        // R2: add boundaries
        apply(0, 'h7F, 'h01, 'h00);   apply(0, 'hFF, 'h01, 'h00);
        apply(1, 'h0F, 'h00, 'h01);   apply(15, 'hC0, 0, 'h00);
        // R3: subtract family
        apply(2, 'h80, 'h01, 'h00);   apply(3, 'h00, 'h00, 'h01);
        apply(4, 'h42, 'h42, 'hD0);   apply(10, 'h80, 0, 'h00);
        apply(10, 'h00, 0, 'h0F);
        // R4, R5, R6, R1 writeback
        apply(8, 'hF0, 'h0F, 'h23);   apply(9, 0, 'h80, 'h02);
        apply(19, 'h00, 0, 'h21);     apply(11, 'h00, 0, 'h02);
        apply(20, 'h55, 0, 'hFF);
        // R7: INC/DEC boundaries
        apply(17, 'h7F, 0, 'h01);     apply(17, 'hFF, 0, 'h00);
        apply(18, 'h80, 0, 'h01);     apply(18, 'h00, 0, 'h00);
        // R8, R9: shifts and rotates
        apply(12, 'h01, 0, 'h02);     apply(13, 'h81, 0, 'h00);
        apply(14, 'h02, 0, 'h01);     apply(16, 'h80, 0, 'h01);
        // R10: decimal adjust paths
        apply(21, 'h9A, 0, 'h00);     apply(21, 'h12, 0, 'h20);
        apply(21, 'h15, 0, 'h01);     apply(21, 'hFF, 0, 'h00);
        // R13: undefined codes, R11 pass-through bits set high
        apply(22, 'h12, 'h34, 'hD5);  apply(31, 'hFF, 'hFF, 'h3A);
        reset_check();
        // Mixed patterns over all codes and flag bytes.
        for (int i = 0; i < 3000; i++)
            apply($urandom_range(0, 31), $urandom_range(0, 255),
                  $urandom_range(0, 255), $urandom_range(0, 255));
        @(negedge clk);
        check_pending();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #100000;
        if (!done) begin
            n_bad++;
            $display("FAIL R12: watchdog expired, got running, expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule